// File: doc/BRIEF.md
# Load-Store Unit with Line Prefetcher

This block is the memory element of a spatial compute array. Producers upstream push access addresses into a deep address queue and push store payloads into a separate, shallower data queue. An access engine takes the oldest queued address, sends one demand access to the L1 cache port, and waits for that access to complete. Only then does it retire the queue entry. A cache miss therefore holds the oldest entry in place, and later addresses pile up behind it.

While the demand side waits, a scan engine walks forward through the queued addresses without removing any of them. Each time it meets an address whose 64-byte line differs from the line it last requested, it sends a line-fill request on the same cache port. Those lines are then resident in L1 by the time the demand side reaches them. Load results leave the block in arrival order, each marked by a one-cycle valid strobe.

Top module: `lsu_prefetch_unit`

## Requirements
- R1: While reset is held, `in_addr_ready` and `in_wdata_ready` are 1, and `mem_req_valid` and `ld_valid` are 0.
- R2: The address queue accepts exactly 256 entries and the data queue exactly 16. The matching ready output is 0 while the queue is full, and a push offered then is not taken.
- R3: Demand accesses leave in arrival order, with at most one in flight. A demand request carries the head address and kind code 0 for a load or 1 for a store.
- R4: A queued address is retired only on a cycle with `mem_rsp_valid` high for its access. No later demand issues before that, and every queued entry is eventually retired.
- R5: A store issues only once its payload is at the head of the data queue, and the request carries that payload. Its completion retires the address entry and the payload together, while a load retires only its address entry.
- R6: Each load completion produces, one cycle later, a single `ld_valid` pulse carrying `mem_rsp_rdata`, in the order the load addresses arrived.
- R7: A prefetch request uses kind code 2 and a line-aligned address (bits 5:0 zero). Its line belongs to a queued address at or after the entry of the previous prefetch.
- R8: A queued address in the same 64-byte line as the last accepted prefetch produces no new prefetch request.
- R9: When a demand access and a prefetch are both pending, the demand access takes the port.
- R10: A demand request that is not accepted stays offered, with the same address, until `mem_req_ready` is 1. A prefetch offer may be withdrawn.
- R11: If the head retires past the scan position, scanning resumes from the new head. Entries that have already retired are never prefetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_addr_valid | input | 1 | Address push request |
| in_addr_ready | output | 1 | Address queue has room |
| in_addr | input | 32 | Byte address of the access |
| in_is_store | input | 1 | 1 for a store, 0 for a load |
| in_wdata_valid | input | 1 | Store payload push request |
| in_wdata_ready | output | 1 | Data queue has room |
| in_wdata | input | 32 | Store payload |
| mem_req_valid | output | 1 | Cache request offered |
| mem_req_ready | input | 1 | Cache accepts the request |
| mem_req_kind | output | 2 | 0 load, 1 store, 2 line prefetch |
| mem_req_addr | output | 32 | Request address (line-aligned for prefetch) |
| mem_req_wdata | output | 32 | Store payload |
| mem_rsp_valid | input | 1 | Outstanding demand access completed |
| mem_rsp_rdata | input | 32 | Load data of the completed access |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | 32 | Load result |

## Verification
Demand issue and prefetch issue compete for the single cache port in the same cycle. This happens whenever a response retires the head and the next address becomes eligible while the scan engine still has a new line to offer. The random phase provokes it by combining short response latencies, a cache ready that drops one cycle in three, and address streams with a mix of sequential runs and jumps. Whenever a prefetch is offered, the bench checks, from its own queue model, that no demand was eligible in that cycle. A directed phase rejects every prefetch so that the head overtakes the scan position, then checks that the next prefetch names only the newly pushed line.

// File: rtl/lsu_pkg.sv
// Shared types of the load-store unit with line prefetcher.
package lsu_pkg;
    // Request kind codes on the cache port; values are part of the port contract.
    typedef enum logic [1:0] {
        REQ_LOAD     = 2'd0,
        REQ_STORE    = 2'd1,
        REQ_PREFETCH = 2'd2
    } req_kind_e;
endpackage

// File: rtl/lsu_addr_queue.sv
// Address queue: circular buffer with a head read port and a second read
// port at any pointer, used by the scan engine.
// Assumes DEPTH is a power of two and that the user never pushes when full
// or pops when empty. Pointers carry one wrap bit.
module lsu_addr_queue #(
    parameter int DEPTH  = 256,
    parameter int EW     = 33,
    parameter int PEEK_W = 32,
    localparam int IW    = $clog2(DEPTH),
    localparam int PW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_entry,
    input  logic          pop,
    output logic          full,
    output logic          empty,
    output logic [EW-1:0] head_entry,
    input  logic [PW-1:0] peek_ptr,
    output logic [PEEK_W-1:0] peek_entry,
    output logic [PW-1:0] head_ptr,
    output logic [PW-1:0] tail_ptr
);
    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] head_q, tail_q;

    // Advance head on pop and tail on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
        end
    end

    // Store a pushed entry at the tail slot.
    always_ff @(posedge clk) begin
        if (push) mem[tail_q[IW-1:0]] <= push_entry;
    end

    assign full       = (tail_q[IW] != head_q[IW]) && (tail_q[IW-1:0] == head_q[IW-1:0]);
    assign empty      = (tail_q == head_q);
    assign head_entry = mem[head_q[IW-1:0]];
    assign peek_entry = mem[peek_ptr[IW-1:0]][PEEK_W-1:0];
    assign head_ptr   = head_q;
    assign tail_ptr   = tail_q;

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r2_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        PW'(tail_q - head_q) <= PW'(DEPTH));
endmodule

// File: rtl/lsu_data_queue.sv
// Store payload queue: plain circular FIFO.
// Assumes DEPTH is a power of two; push is gated by ready at the caller.
module lsu_data_queue #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          ready,
    output logic          valid,
    output logic [DW-1:0] head_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] head_q, tail_q;

    // Pointer update on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
        end
    end

    // Payload write at the tail slot.
    always_ff @(posedge clk) begin
        if (push) mem[tail_q[IW-1:0]] <= push_data;
    end

    assign ready     = !((tail_q[IW] != head_q[IW]) && (tail_q[IW-1:0] == head_q[IW-1:0]));
    assign valid     = (tail_q != head_q);
    assign head_data = mem[head_q[IW-1:0]];

    a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> valid);
endmodule

// File: rtl/lsu_access_engine.sv
// In-order demand engine: offers the head access, then waits for its
// completion before retiring it. One access is in flight at a time.
// Assumes mem_rsp_valid is only raised for the access in flight.
module lsu_access_engine #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_valid,
    input  logic          head_is_store,
    input  logic          data_valid,
    input  logic          port_ready,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_rdata,
    output logic          dem_req,
    output logic          pop_addr,
    output logic          pop_data,
    output logic          ld_valid,
    output logic [DW-1:0] ld_data
);
    logic waiting;
    logic done;

    assign dem_req  = !waiting && head_valid && (!head_is_store || data_valid);
    assign done     = waiting && rsp_valid;
    assign pop_addr = done;
    assign pop_data = done && head_is_store;

    // Track whether a demand access is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                     waiting <= 1'b0;
        else if (done)                  waiting <= 1'b0;
        else if (dem_req && port_ready) waiting <= 1'b1;
    end

    // Register the load result one cycle after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= done && !head_is_store;
            if (done) ld_data <= rsp_rdata;
        end
    end

    a_r10_demand_held: assert property (@(posedge clk) disable iff (!rst_n)
        dem_req && !port_ready |=> dem_req);
    a_r6_result_after_completion: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(rsp_valid));
    a_r4_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        dem_req && port_ready |=> !dem_req);
endmodule

// File: rtl/lsu_prefetch_scan.sv
// Scan engine: walks queued addresses ahead of the head, one entry per
// cycle at most, and offers a line fill for each line that differs from
// the last accepted one. Never passes the tail; rejoins the head when
// the head retires the entry it is parked on.
module lsu_prefetch_scan #(
    parameter int AW       = 32,
    parameter int LINE_OFF = 6,
    parameter int PW       = 9,
    localparam int LW      = AW - LINE_OFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] head_ptr,
    input  logic [PW-1:0] tail_ptr,
    input  logic          pop,
    input  logic [AW-1:0] scan_addr,
    input  logic          pf_fire,
    output logic [PW-1:0] scan_ptr,
    output logic          pf_valid,
    output logic [LW-1:0] pf_line
);
    logic [PW-1:0] scan_q;
    logic          last_vld;
    logic [LW-1:0] last_line;
    logic          scan_has, same, advance;

    assign scan_has = (scan_q != tail_ptr);
    assign pf_line  = scan_addr[AW-1:LINE_OFF];
    assign same     = last_vld && (pf_line == last_line);
    assign pf_valid = scan_has && !same;
    assign advance  = scan_has && (same || pf_fire);
    assign scan_ptr = scan_q;

    // Step the scan pointer, or drag it along when the head retires under it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                scan_q <= '0;
        else if (advance || (pop && scan_q == head_ptr)) scan_q <= scan_q + 1'b1;
    end

    // Remember the line of the last accepted prefetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vld  <= 1'b0;
            last_line <= '0;
        end else if (pf_fire) begin
            last_vld  <= 1'b1;
            last_line <= pf_line;
        end
    end

    a_r11_scan_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        PW'(scan_q - head_ptr) <= PW'(tail_ptr - head_ptr));
    a_r7_line_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        pf_fire |=> last_vld && (last_line == $past(pf_line)));
    a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        pf_fire |=> !(pf_valid && pf_line == $past(pf_line)));
endmodule

// File: rtl/lsu_prefetch_unit.sv
// Load-store unit with line prefetcher (top).
// Queues addresses and store payloads, issues demand accesses in order
// with one in flight, and shares the cache request port with a scan
// engine that fills upcoming lines. Demand has priority on the port.
module lsu_prefetch_unit #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int ADDR_DEPTH = 256,
    parameter int DATA_DEPTH = 16,
    parameter int LINE_BYTES = 64,
    localparam int LINE_OFF  = $clog2(LINE_BYTES),
    localparam int LW        = AW - LINE_OFF,
    localparam int APW       = $clog2(ADDR_DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_addr_valid,
    output logic          in_addr_ready,
    input  logic [AW-1:0] in_addr,
    input  logic          in_is_store,
    input  logic          in_wdata_valid,
    output logic          in_wdata_ready,
    input  logic [DW-1:0] in_wdata,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [1:0]    mem_req_kind,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata,
    output logic          ld_valid,
    output logic [DW-1:0] ld_data
);
    import lsu_pkg::*;

    logic          a_full, a_empty;
    logic [AW:0]   head_entry;
    logic [AW-1:0] scan_addr;
    logic [APW-1:0] head_ptr, tail_ptr, scan_ptr;
    logic          d_valid;
    logic [DW-1:0] d_head;
    logic          dem_req, pop_addr, pop_data;
    logic          pf_valid, pf_fire;
    logic [LW-1:0] pf_line;
    req_kind_e     kind;

    assign in_addr_ready = !a_full;

    lsu_addr_queue #(.DEPTH(ADDR_DEPTH), .EW(AW + 1), .PEEK_W(AW)) i_addr_q (
        .clk(clk), .rst_n(rst_n),
        .push(in_addr_valid && !a_full), .push_entry({in_is_store, in_addr}),
        .pop(pop_addr), .full(a_full), .empty(a_empty), .head_entry(head_entry),
        .peek_ptr(scan_ptr), .peek_entry(scan_addr),
        .head_ptr(head_ptr), .tail_ptr(tail_ptr)
    );

    lsu_data_queue #(.DEPTH(DATA_DEPTH), .DW(DW)) i_data_q (
        .clk(clk), .rst_n(rst_n),
        .push(in_wdata_valid && in_wdata_ready), .push_data(in_wdata),
        .pop(pop_data), .ready(in_wdata_ready), .valid(d_valid), .head_data(d_head)
    );

    lsu_access_engine #(.DW(DW)) i_engine (
        .clk(clk), .rst_n(rst_n),
        .head_valid(!a_empty), .head_is_store(head_entry[AW]), .data_valid(d_valid),
        .port_ready(mem_req_ready), .rsp_valid(mem_rsp_valid), .rsp_rdata(mem_rsp_rdata),
        .dem_req(dem_req), .pop_addr(pop_addr), .pop_data(pop_data),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    lsu_prefetch_scan #(.AW(AW), .LINE_OFF(LINE_OFF), .PW(APW)) i_scan (
        .clk(clk), .rst_n(rst_n),
        .head_ptr(head_ptr), .tail_ptr(tail_ptr), .pop(pop_addr),
        .scan_addr(scan_addr), .pf_fire(pf_fire),
        .scan_ptr(scan_ptr), .pf_valid(pf_valid), .pf_line(pf_line)
    );

    // Port arbitration: a prefetch goes out only when no demand is offered.
    assign pf_fire       = pf_valid && !dem_req && mem_req_ready;
    assign mem_req_valid = dem_req || pf_valid;
    assign mem_req_wdata = d_head;
    assign mem_req_kind  = kind;

    // Select request kind and address for the port.
    always_comb begin
        if (dem_req) begin
            kind         = head_entry[AW] ? REQ_STORE : REQ_LOAD;
            mem_req_addr = head_entry[AW-1:0];
        end else begin
            kind         = REQ_PREFETCH;
            mem_req_addr = {pf_line, {LINE_OFF{1'b0}}};
        end
    end

    a_r9_demand_first: assert property (@(posedge clk) disable iff (!rst_n)
        dem_req |-> (mem_req_kind != REQ_PREFETCH));
    a_r5_store_pops_pair: assert property (@(posedge clk) disable iff (!rst_n)
        pop_data |-> pop_addr);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> !mem_req_valid && !ld_valid);
endmodule

// File: tb/test_lsu_prefetch_unit.sv
// Self-checking bench: directed prefetch, catch-up and capacity phases,
// then a seeded random phase against a queue model of the block.
module test_lsu_prefetch_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic in_addr_valid, in_is_store, in_wdata_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] in_addr, in_wdata, mem_rsp_rdata;
    logic in_addr_ready, in_wdata_ready, mem_req_valid, ld_valid;
    logic [1:0] mem_req_kind;
    logic [31:0] mem_req_addr, mem_req_wdata, ld_data;

    lsu_prefetch_unit i_lsu_prefetch_unit (
        .clk(clk), .rst_n(rst_n),
        .in_addr_valid(in_addr_valid), .in_addr_ready(in_addr_ready),
        .in_addr(in_addr), .in_is_store(in_is_store),
        .in_wdata_valid(in_wdata_valid), .in_wdata_ready(in_wdata_ready), .in_wdata(in_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_kind(mem_req_kind), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [31:0] q_addr[$];
    bit          q_st[$];
    logic [31:0] dq[$];
    logic [31:0] exp_ld[$];
    logic [31:0] hist[$];
    logic [31:0] pf_log[$];
    int          pf_pos = 0;
    logic [31:0] last_pf = '0;
    bit          pf_seen = 0;
    bit          outst = 0, out_st = 0, hold = 0;
    logic [31:0] out_addr = '0;
    int          lat = 0, rr_mode = 1;
    bit          prev_dem_wait = 0;
    logic [31:0] prev_dem_addr = '0;

    function automatic logic [31:0] ref_rdata(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[31:16]};
    endfunction

    function automatic logic [31:0] line_of(input logic [31:0] a);
        return a & ~32'h3F;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: check outputs, drive inputs, update the model.
    task automatic cycle(input bit av, input logic [31:0] a, input bit st, input bit dv, input logic [31:0] d);
        bit elig;
        bit s;
        logic [31:0] e;
        @(negedge clk);
        if (ld_valid) begin
            if (exp_ld.size() == 0) check(0, "R6 unexpected load result", ld_data, 0);
            else begin
                e = exp_ld.pop_front();
                check(ld_data == e, "R6 load result order", ld_data, e);
            end
        end
        if (prev_dem_wait)
            check(mem_req_valid && mem_req_kind != 2'd2 && mem_req_addr == prev_dem_addr,
                  "R10 demand held until accepted", mem_req_addr, prev_dem_addr);
        if (mem_req_valid) begin
            if (mem_req_kind == 2'd2) begin
                check(mem_req_addr[5:0] == 6'd0, "R7 prefetch line aligned", mem_req_addr, line_of(mem_req_addr));
                if (pf_seen) check(mem_req_addr != last_pf, "R8 no repeat of last line", mem_req_addr, last_pf);
                elig = !outst && q_addr.size() > 0 && (!q_st[0] || dq.size() > 0);
                check(!elig, "R9 demand priority over prefetch", 32'(elig), 0);
            end else begin
                check(!outst, "R3 single access in flight", 32'(outst), 0);
                if (q_addr.size() == 0) check(0, "R3 demand without entry", mem_req_addr, 0);
                else begin
                    check(mem_req_addr == q_addr[0], "R3 in-order address", mem_req_addr, q_addr[0]);
                    check(mem_req_kind == {1'b0, q_st[0]}, "R3 access kind", 32'(mem_req_kind), 32'(q_st[0]));
                    if (q_st[0]) begin
                        if (dq.size() == 0) check(0, "R5 store issued without payload", mem_req_wdata, 0);
                        else check(mem_req_wdata == dq[0], "R5 store payload", mem_req_wdata, dq[0]);
                    end
                end
            end
        end
        in_addr_valid = av; in_addr = a; in_is_store = st;
        in_wdata_valid = dv; in_wdata = d;
        case (rr_mode)
            0: mem_req_ready = ($urandom % 3) != 0;
            1: mem_req_ready = 1'b1;
            2: mem_req_ready = (mem_req_kind != 2'd2);
            default: mem_req_ready = 1'b0;
        endcase
        mem_rsp_valid = 1'b0;
        if (outst && !hold) begin
            if (lat == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = ref_rdata(out_addr);
            end else lat--;
        end
        #1;
        prev_dem_wait = mem_req_valid && mem_req_kind != 2'd2 && !mem_req_ready;
        prev_dem_addr = mem_req_addr;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_kind == 2'd2) begin
                bit found = 0;
                pf_log.push_back(mem_req_addr);
                last_pf = mem_req_addr;
                pf_seen = 1;
                for (int i = pf_pos; i < hist.size(); i++) begin
                    if (!found && line_of(hist[i]) == mem_req_addr) begin
                        found = 1;
                        pf_pos = i + 1;
                    end
                end
                check(found, "R7 prefetch line from a later queued address", mem_req_addr, 0);
            end else begin
                outst = 1; out_addr = mem_req_addr; out_st = mem_req_kind[0];
                lat = $urandom % 5;
            end
        end
        if (mem_rsp_valid) begin
            outst = 0;
            void'(q_addr.pop_front());
            s = q_st.pop_front();
            if (s) void'(dq.pop_front());
            else exp_ld.push_back(ref_rdata(out_addr));
        end
        if (in_addr_valid && in_addr_ready) begin
            q_addr.push_back(in_addr); q_st.push_back(in_is_store); hist.push_back(in_addr);
        end
        if (in_wdata_valid && in_wdata_ready) dq.push_back(in_wdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0);
    endtask

    // Run until every queued access has retired and every result is out.
    task automatic drain();
        for (int i = 0; i < 6000; i++) begin
            int nst = 0;
            if (q_addr.size() == 0 && !outst && exp_ld.size() == 0) break;
            foreach (q_st[j]) if (q_st[j]) nst++;
            cycle(0, 0, 0, dq.size() < nst, $urandom);
        end
        idle(2);
        check(q_addr.size() == 0, "R4 all entries retired", q_addr.size(), 0);
        check(exp_ld.size() == 0, "R6 all load results delivered", exp_ld.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] wp;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        in_addr_valid = 0; in_addr = 0; in_is_store = 0;
        in_wdata_valid = 0; in_wdata = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_addr_ready == 1'b1, "R1 address ready in reset", 32'(in_addr_ready), 1);
        check(in_wdata_ready == 1'b1, "R1 data ready in reset", 32'(in_wdata_ready), 1);
        check(mem_req_valid == 1'b0, "R1 no request in reset", 32'(mem_req_valid), 0);
        check(ld_valid == 1'b0, "R1 no result in reset", 32'(ld_valid), 0);
        rst_n = 1'b1;

        // Directed: demand stalled, scan prefetches distinct lines only (R7, R8).
        rr_mode = 1; hold = 1;
        cycle(1, 32'h100, 0, 0, 0);
        cycle(1, 32'h104, 0, 0, 0);
        cycle(1, 32'h13C, 0, 0, 0);
        cycle(1, 32'h140, 0, 0, 0);
        cycle(1, 32'h144, 0, 0, 0);
        cycle(1, 32'h100, 0, 0, 0);
        cycle(1, 32'h1000, 0, 0, 0);
        idle(20);
        check(pf_log.size() == 4, "R8 one prefetch per new line", pf_log.size(), 4);
        if (pf_log.size() == 4) begin
            check(pf_log[0] == 32'h100,  "R7 first prefetch line", pf_log[0], 32'h100);
            check(pf_log[1] == 32'h140,  "R7 second prefetch line", pf_log[1], 32'h140);
            check(pf_log[2] == 32'h100,  "R8 line revisited after change", pf_log[2], 32'h100);
            check(pf_log[3] == 32'h1000, "R7 far line", pf_log[3], 32'h1000);
        end
        check(q_addr.size() == 7, "R4 miss holds the head entry", q_addr.size(), 7);
        hold = 0;
        drain();

        // Directed: prefetches rejected, head overtakes scan (R11).
        pf_log.delete();
        rr_mode = 2;
        cycle(1, 32'h2000, 0, 0, 0);
        cycle(1, 32'h2040, 0, 0, 0);
        cycle(1, 32'h2080, 0, 0, 0);
        drain();
        check(pf_log.size() == 0, "R11 no prefetch accepted while rejected", pf_log.size(), 0);
        rr_mode = 1;
        cycle(1, 32'h9000, 0, 0, 0);
        idle(10);
        check(pf_log.size() == 1, "R11 scan resumes at new head", pf_log.size(), 1);
        if (pf_log.size() > 0) check(pf_log[0] == 32'h9000, "R11 only the new line prefetched", pf_log[0], 32'h9000);
        drain();

        // Directed: queue capacities (R2).
        rr_mode = 3;
        for (int i = 0; i < 256; i++) cycle(1, 32'h4000 + 32'(i) * 4, 0, 0, 0);
        check(in_addr_ready == 1'b1, "R2 room with 255 queued", 32'(in_addr_ready), 1);
        cycle(1, 32'hDEAD0000, 0, 0, 0);
        check(in_addr_ready == 1'b0, "R2 address queue full at 256", 32'(in_addr_ready), 0);
        cycle(1, 32'hDEAD0004, 0, 0, 0);
        check(q_addr.size() == 256, "R2 push refused when full", q_addr.size(), 256);
        for (int i = 0; i < 16; i++) cycle(0, 0, 0, 1, 32'hD000 + 32'(i));
        check(in_wdata_ready == 1'b1, "R2 data room with 15 queued", 32'(in_wdata_ready), 1);
        cycle(0, 0, 0, 1, 32'hBAD);
        check(in_wdata_ready == 1'b0, "R2 data queue full at 16", 32'(in_wdata_ready), 0);
        rr_mode = 1;
        drain();

        // Random phase: mixed loads and stores, random ready and latency (R3-R10).
        rr_mode = 0;
        wp = 32'h10000;
        for (int i = 0; i < 4000; i++) begin
            bit av = ($urandom % 2) == 0;
            bit st = ($urandom % 4) == 0;
            bit dv = ($urandom % 5) < 2;
            if (av) begin
                if (($urandom % 8) == 0) wp = 32'h10000 + ($urandom % 1024) * 4;
                else wp = wp + 4;
            end
            cycle(av, wp, st, dv, $urandom);
        end
        rr_mode = 1;
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule